// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block lets software on one processor send an interrupt message to another processor, or to all of them. Software programs two 32-bit command words over a simple register bus. The upper word carries the target processor number. The lower word carries the delivery mode, the vector, the trigger and polarity flags and a broadcast flag. Writing the lower word is the send trigger: the block latches a message and presents it on an outbound valid/ready message port. The message stays there until the interconnect takes it.

While the message is waiting, a status bit in the lower word reads as busy. Software polls this bit to learn when the send has finished. Two delivery modes carry special meaning. One resets a target processor. The other starts a target processor at the 4 KiB page given in the vector field. A shorthand sends the message to every processor, the sender included.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset both command words read as zero, the busy bit (low word bit 12) reads 0 and `msg_valid` is low.
- R2: A write to byte offset 0x310 stores the destination processor number from bits 31:24. Reading the same offset returns that number in bits 31:24 and zeros elsewhere.
- R3: A write to byte offset 0x300 while the unit is idle raises `msg_valid` on the cycle after the write. The message fields come from the written word: `msg_mode` from bits 10:8, `msg_vector` from bits 7:0, `msg_assert` from bit 14, `msg_level` from bit 15, and `msg_dest` from the stored bits 31:24 of the high word.
- R4: Reading offset 0x300 returns bit 12 as 1 while a message is pending and as 0 once it has been accepted. Written bit 12 is not stored. The other readable bits are 19, 15, 14, 10:8 and 7:0, as last accepted; all remaining bits read 0.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field hold steady. After a clock edge where both are high, `msg_valid` is low on the next cycle.
- R6: When bit 19 of the low word is set, the message goes to all processors including the sender. `msg_bcast` is 1 and `msg_dest` is 0xFF whatever the high word holds.
- R7: A write to offset 0x300 while busy is ignored. The pending message, its readback and the number of messages sent are unchanged.
- R8: Mode 3'b101 (reset a processor) and mode 3'b110 (start a processor) pass through unchanged. For a start message the vector equals the start address shifted right by 12.
- R9: A write to offset 0x310 while a message is pending does not change that message's `msg_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Interconnect takes the message |
| msg_dest | output | 8 | Destination processor number |
| msg_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector or start page |
| msg_level | output | 1 | Level-triggered delivery |
| msg_assert | output | 1 | Assert (1) or deassert (0) |
| msg_bcast | output | 1 | Send to all processors, self included |

## Verification
The send path is driven with four kinds of pattern:
- A targeted level reset message held against a stalled `msg_ready`. This separates correct holding of the message from early release, and shows the busy bit flipping at the right cycle.
- A start message built from an address. This shows that the vector field is taken unaltered from the written word.
- A broadcast written after the high word held a real target. This tells broadcast substitution apart from plain destination pass-through.
- Back-to-back sends with `msg_ready` held high, plus writes made while busy. These separate "accept a new write once idle" from "drop a write while busy", counted through a scoreboard of expected messages.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   // Delivery modes decoded by receiving processors
   typedef enum logic [2:0] {
      DM_FIXED   = 3'b000,
      DM_LOWEST  = 3'b001,
      DM_SMI     = 3'b010,
      DM_NMI     = 3'b100,
      DM_RESET   = 3'b101,
      DM_STARTUP = 3'b110
   } ipi_mode_e;

   // Bit positions in the low command word
   localparam int LO_VEC_LSB  = 0;
   localparam int LO_MODE_LSB = 8;
   localparam int LO_BUSY_BIT = 12;
   localparam int LO_AST_BIT  = 14;
   localparam int LO_LVL_BIT  = 15;
   localparam int LO_BC_BIT   = 19;

   // Top bit of the destination field in the high word
   localparam int HI_ID_MSB   = 31;

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
   import ipi_pkg::*;
#(
   parameter int               DW     = 32,
   parameter int               AW     = 12,
   parameter int               ID_W   = 8,
   parameter int               VEC_W  = 8,
   parameter logic [AW-1:0]    LO_OFF = 'h300,
   parameter logic [AW-1:0]    HI_OFF = 'h310
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              busy,
   output logic              lo_wr,
   output logic [ID_W-1:0]   hi_id,
   output logic [2:0]        nxt_mode,
   output logic [VEC_W-1:0]  nxt_vec,
   output logic              nxt_lvl,
   output logic              nxt_ast,
   output logic              nxt_bc
);

   localparam int ID_LSB = HI_ID_MSB - ID_W + 1;

   logic              hi_wr;
   logic [2:0]        lo_mode_q;
   logic [VEC_W-1:0]  lo_vec_q;
   logic              lo_lvl_q, lo_ast_q, lo_bc_q;

   assign hi_wr = bus_we && (bus_addr == HI_OFF);
   assign lo_wr = bus_we && (bus_addr == LO_OFF);

   // Field decode of the word on the bus
   assign nxt_mode = bus_wdata[LO_MODE_LSB +: 3];
   assign nxt_vec  = bus_wdata[LO_VEC_LSB +: VEC_W];
   assign nxt_lvl  = bus_wdata[LO_LVL_BIT];
   assign nxt_ast  = bus_wdata[LO_AST_BIT];
   assign nxt_bc   = bus_wdata[LO_BC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_id <= '0;
      end else if (hi_wr) begin
         hi_id <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_mode_q <= '0;
         lo_vec_q  <= '0;
         lo_lvl_q  <= 1'b0;
         lo_ast_q  <= 1'b0;
         lo_bc_q   <= 1'b0;
      end else if (lo_wr && !busy) begin
         lo_mode_q <= nxt_mode;
         lo_vec_q  <= nxt_vec;
         lo_lvl_q  <= nxt_lvl;
         lo_ast_q  <= nxt_ast;
         lo_bc_q   <= nxt_bc;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == HI_OFF) begin
         bus_rdata[ID_LSB +: ID_W] = hi_id;
      end else if (bus_addr == LO_OFF) begin
         bus_rdata[LO_VEC_LSB +: VEC_W] = lo_vec_q;
         bus_rdata[LO_MODE_LSB +: 3]    = lo_mode_q;
         bus_rdata[LO_BUSY_BIT]         = busy;
         bus_rdata[LO_AST_BIT]          = lo_ast_q;
         bus_rdata[LO_LVL_BIT]          = lo_lvl_q;
         bus_rdata[LO_BC_BIT]           = lo_bc_q;
      end
   end

   // R4: the busy bit in the readback follows pending state one cycle after a launch
   p_busy_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !busy) |=> busy);

endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch #(
   parameter int ID_W       = 8,
   parameter int VEC_W      = 8,
   parameter bit BC_ALL_IDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic [ID_W-1:0]   hi_id,
   input  logic [2:0]        nxt_mode,
   input  logic [VEC_W-1:0]  nxt_vec,
   input  logic              nxt_lvl,
   input  logic              nxt_ast,
   input  logic              nxt_bc,
   output logic              pend,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [ID_W-1:0]   msg_dest,
   output logic [2:0]        msg_mode,
   output logic [VEC_W-1:0]  msg_vector,
   output logic              msg_level,
   output logic              msg_assert,
   output logic              msg_bcast
);

   logic             take;
   logic [ID_W-1:0]  dest_sel;

   assign take = lo_wr && !pend;

   // Variant: broadcast rewrites the destination to all ones, or keeps it
   generate
      if (BC_ALL_IDS) begin : g_bc_ones
         assign dest_sel = nxt_bc ? {ID_W{1'b1}} : hi_id;
      end else begin : g_bc_keep
         assign dest_sel = hi_id;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (take) begin
         pend <= 1'b1;
      end else if (msg_ready) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_dest   <= '0;
         msg_mode   <= '0;
         msg_vector <= '0;
         msg_level  <= 1'b0;
         msg_assert <= 1'b0;
         msg_bcast  <= 1'b0;
      end else if (take) begin
         msg_dest   <= dest_sel;
         msg_mode   <= nxt_mode;
         msg_vector <= nxt_vec;
         msg_level  <= nxt_lvl;
         msg_assert <= nxt_ast;
         msg_bcast  <= nxt_bc;
      end
   end

   assign msg_valid = pend;

   // R3: an idle low-word write raises valid on the next cycle with the written mode
   p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !msg_valid) |=> (msg_valid && msg_mode == $past(nxt_mode)
                                 && msg_vector == $past(nxt_vec)));

   // R5: a stalled message keeps every field
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_mode)
                                     && $stable(msg_vector) && $stable(msg_level)
                                     && $stable(msg_assert) && $stable(msg_bcast)));

   // R5: an accepted message is gone on the next cycle
   p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);

   // R7 / R9: writes while pending leave the message alone
   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> ($stable(msg_dest) || !msg_valid || $past(msg_ready)));

   // R6: broadcast messages carry the all-ones destination
   p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && nxt_bc && BC_ALL_IDS) |=> (msg_dest == {ID_W{1'b1}}));

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
   parameter int            DW         = 32,
   parameter int            AW         = 12,
   parameter int            ID_W       = 8,
   parameter int            VEC_W      = 8,
   parameter logic [AW-1:0] LO_OFF     = 'h300,
   parameter logic [AW-1:0] HI_OFF     = 'h310,
   parameter bit            BC_ALL_IDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [ID_W-1:0]   msg_dest,
   output logic [2:0]        msg_mode,
   output logic [VEC_W-1:0]  msg_vector,
   output logic              msg_level,
   output logic              msg_assert,
   output logic              msg_bcast
);

   // Elaboration-time parameter checks
   generate
      if (DW != 32) begin : g_bad_dw
         $error("ipi_cmd_unit: DW must be 32");
      end
      if (ID_W < 1 || ID_W > 8) begin : g_bad_id
         $error("ipi_cmd_unit: ID_W must be 1..8");
      end
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
         $error("ipi_cmd_unit: VEC_W must be 1..8");
      end
      if (AW < 10) begin : g_bad_aw
         $error("ipi_cmd_unit: AW too small for the command offsets");
      end
      if (LO_OFF == HI_OFF) begin : g_bad_off
         $error("ipi_cmd_unit: command word offsets must differ");
      end
   endgenerate

   logic              busy, lo_wr;
   logic [ID_W-1:0]   hi_id;
   logic [2:0]        nxt_mode;
   logic [VEC_W-1:0]  nxt_vec;
   logic              nxt_lvl, nxt_ast, nxt_bc;

   ipi_cmd_regs #(
      .DW(DW), .AW(AW), .ID_W(ID_W), .VEC_W(VEC_W),
      .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .busy(busy), .lo_wr(lo_wr), .hi_id(hi_id),
      .nxt_mode(nxt_mode), .nxt_vec(nxt_vec), .nxt_lvl(nxt_lvl),
      .nxt_ast(nxt_ast), .nxt_bc(nxt_bc)
   );

   ipi_msg_launch #(
      .ID_W(ID_W), .VEC_W(VEC_W), .BC_ALL_IDS(BC_ALL_IDS)
   ) u_launch (
      .clk(clk), .rst_n(rst_n),
      .lo_wr(lo_wr), .hi_id(hi_id),
      .nxt_mode(nxt_mode), .nxt_vec(nxt_vec), .nxt_lvl(nxt_lvl),
      .nxt_ast(nxt_ast), .nxt_bc(nxt_bc),
      .pend(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_dest(msg_dest), .msg_mode(msg_mode), .msg_vector(msg_vector),
      .msg_level(msg_level), .msg_assert(msg_assert), .msg_bcast(msg_bcast)
   );

endmodule

// File: tb/ipi_cmd_unit_tb.sv
module ipi_cmd_unit_tb;

   localparam logic [11:0] LO = 12'h300;
   localparam logic [11:0] HI = 12'h310;

   typedef struct packed {
      logic [7:0] dest;
      logic [2:0] mode;
      logic [7:0] vec;
      logic       lvl;
      logic       ast;
      logic       bc;
   } exp_msg_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid, msg_ready = 1'b0;
   logic [7:0]  msg_dest, msg_vector;
   logic [2:0]  msg_mode;
   logic        msg_level, msg_assert, msg_bcast;

   int checks = 0, errors = 0, popped = 0;
   bit done = 1'b0;
   exp_msg_t sb[$];

   always #2.5 clk = ~clk;

   ipi_cmd_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
      .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_level(msg_level),
      .msg_assert(msg_assert), .msg_bcast(msg_bcast)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic set_ready(input logic v);
      @(posedge clk); #1;
      msg_ready = v;
   endtask

   // Driver: expected message derived from the words software writes
   task automatic send(input logic [7:0] hi_dest, input logic [31:0] lo);
      exp_msg_t e;
      e.mode = lo[10:8];
      e.vec  = lo[7:0];
      e.lvl  = lo[15];
      e.ast  = lo[14];
      e.bc   = lo[19];
      e.dest = lo[19] ? 8'hFF : hi_dest;
      sb.push_back(e);
      wr(LO, lo);
   endtask

   // Monitor: compare each accepted message against the scoreboard
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         exp_msg_t got;
         got = '{dest: msg_dest, mode: msg_mode, vec: msg_vector,
                 lvl: msg_level, ast: msg_assert, bc: msg_bcast};
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 unexpected message actual=%h expected=none", got);
         end else begin
            exp_msg_t e;
            e = sb.pop_front();
            popped++;
            chk("R3/R6/R8 message fields", 32'(got), 32'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [31:0] st_addr;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 valid", 32'(msg_valid), 0);
      rd(LO, r); chk("R1 low word", r, 0);
      rd(HI, r); chk("R1 high word", r, 0);

      // R2 destination storage
      wr(HI, 32'h2A00_00FF);
      rd(HI, r); chk("R2 high readback", r, 32'h2A00_0000);

      // R3/R4/R5 targeted level reset message against a stall
      send(8'h2A, 32'h0000_C500);
      chk("R3 valid after write", 32'(msg_valid), 1);
      rd(LO, r); chk("R4 busy set", r, 32'h0000_D500);
      repeat (3) @(posedge clk);
      #1;
      chk("R5 valid held", 32'(msg_valid), 1);
      chk("R5 dest held", 32'(msg_dest), 32'h2A);

      // R7 write while busy is dropped
      wr(LO, 32'h0000_069F);
      rd(LO, r); chk("R7 readback unchanged", r, 32'h0000_D500);
      chk("R7 vector unchanged", 32'(msg_vector), 0);
      chk("R7 mode unchanged", 32'(msg_mode), 5);

      // R9 high write while pending
      wr(HI, 32'h1100_0000);
      #0 chk("R9 dest unchanged", 32'(msg_dest), 32'h2A);
      rd(HI, r); chk("R2 high rewrite", r, 32'h1100_0000);

      set_ready(1'b1);
      set_ready(1'b0);
      chk("R5 valid dropped", 32'(msg_valid), 0);
      rd(LO, r); chk("R4 busy clear", r, 32'h0000_C500);

      // R8 start message: vector = address >> 12
      st_addr = 32'h0009_F000;
      set_ready(1'b1);
      send(8'h11, 32'h0000_0600 | (st_addr >> 12));
      repeat (2) @(posedge clk);
      #1 chk("R8 start accepted", 32'(msg_valid), 0);

      // R6 broadcast to all including self
      send(8'h11, 32'h0008_8500);
      repeat (2) @(posedge clk);
      #1;
      rd(LO, r); chk("R6 broadcast readback", r, 32'h0008_8500);

      // R3/R4 back-to-back sends with ready high; bit 12 written is not stored
      send(8'h11, 32'h0000_4040);
      send(8'h11, 32'h0000_5041);
      repeat (3) @(posedge clk);
      #1;
      rd(LO, r); chk("R4 bit 12 not stored", r, 32'h0000_4041);

      chk("R7 message count", 32'(popped), 5);
      chk("R3 scoreboard empty", 32'(sb.size()), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule